// File: doc/BRIEF.md
# Resumable Framed Serial Register Loader

This block is the write side of a device serial port. An external host drives a serial clock, an active-low frame strobe, a destination-select line and a serial data line. The block samples all four with its own system clock. While the frame strobe is low, it shifts in one data bit on each rising edge of the serial clock, most significant bit first. When the twenty-fourth bit arrives, it commits the whole word to one of two registers: the control register or the calibration register. The select line picks which one.

The host may raise the frame strobe partway through a word and lower it again later. The bit position is kept across that gap, so shifting resumes with the next bit. The select line must hold one value for the whole write. If it differs while the frame is active, the partial word is discarded and a one-cycle error pulse is raised. Any further bits in that frame are then ignored. Both registers are always visible at the outputs, and each commit is marked by a one-cycle strobe.

The serial clock must run at no more than one quarter of the system clock. It rests low between transfers.

Top module: `serial_word_loader`

## Requirements
- R1: A synchronous active-high reset clears both registers, the bit count and the shift register. After reset both register outputs read zero and no commit strobe is raised.
- R2: A word is exactly 24 bits, taken most significant bit first. The commit strobe is high for exactly one system-clock cycle, and only after the 24th bit of a word.
- R3: When the select line is low (0), the word goes to the control register. When it is high (1), the word goes to the calibration register. The other register keeps its value.
- R4: A data bit is taken only at the rising edge of the serial clock. Changing the data line while the serial clock is high has no effect on the stored word.
- R5: If the frame strobe goes high partway through a word, no commit takes place and the bit count is held. After the strobe goes low again, the next bit continues the same word.
- R6: Rising edges of the serial clock while the frame strobe is high take no bits.
- R7: If the select line differs from its value at the word's first bit while the frame strobe is low, the following happens: a one-cycle error pulse is raised, the partial word is discarded, and no commit takes place. The remaining bits of that frame are ignored, and the next frame starts a fresh word.
- R8: An abort input drops any partially received word. The next bit taken starts a new word at its most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Drops any partially received word |
| sclk_i | input | 1 | External serial clock (asynchronous) |
| frame_n_i | input | 1 | Active-low frame strobe (asynchronous) |
| sel_i | input | 1 | Destination select: 0 control, 1 calibration |
| sdata_i | input | 1 | Serial data, MSB first |
| ctrl_o | output | 24 | Control register contents |
| cal_o | output | 24 | Calibration register contents |
| commit_o | output | 1 | One-cycle pulse when a word is committed |
| sel_err_o | output | 1 | One-cycle pulse when a word is discarded for a select change |

## Verification
The hardest state to reach is a partial word held across a frame gap. To reach it, the host must stop at an arbitrary bit, release the frame, and later resume so that the bit count lines up exactly at 24. The vector table therefore splits words at several bit positions, including after bit one and before the last bit. The directed tests also hold a half word idle for many cycles. A select change is also forced on an open word, both while the frame is active and across a gap. This confirms that the discarded bits never leak into the next word.

// File: rtl/sloader_pkg.sv
package sloader_pkg;
  typedef enum logic {TGT_CTRL = 1'b0, TGT_CAL = 1'b1} target_e;
  localparam int NUM_TGT = 2;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sl_shift_core.sv
module sl_shift_core #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              sclk,
  input  logic              frame_n,
  input  logic              sel,
  input  logic              sdata,
  output logic              done_o,
  output logic              done_sel_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic              lock_sel_q;
  logic              drop_q;

  logic rise, active, open_word, mismatch, take;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    rise      = sclk & ~sclk_q;
    active    = ~frame_n;
    open_word = (cnt_q != '0);
    mismatch  = active && open_word && !drop_q && (sel != lock_sel_q);
    take      = rise && active && !drop_q && !mismatch;
    shifted   = {shreg_q[WORD_W-2:0], sdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q     <= 1'b0;
      cnt_q      <= '0;
      shreg_q    <= '0;
      lock_sel_q <= 1'b0;
      drop_q     <= 1'b0;
      done_o     <= 1'b0;
      done_sel_o <= 1'b0;
      word_o     <= '0;
      err_o      <= 1'b0;
    end else begin
      sclk_q <= sclk;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (abort) begin
        cnt_q  <= '0;
        drop_q <= 1'b0;
      end else if (mismatch) begin
        cnt_q  <= '0;
        err_o  <= 1'b1;
        drop_q <= 1'b1;
      end else if (drop_q && !active) begin
        drop_q <= 1'b0;
      end else if (take) begin
        shreg_q <= shifted;
        if (cnt_q == '0) lock_sel_q <= sel;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          done_o     <= 1'b1;
          done_sel_o <= lock_sel_q;
          word_o     <= shifted;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2: the bit count never passes the last bit position
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R7: a discarded word never commits in the same cycle
  a_r7_err_excl: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !done_o);
  // R7: while dropping the rest of a frame nothing commits
  a_r7_drop_quiet: assert property (@(posedge clk) disable iff (rst)
    drop_q |=> !done_o);
  // R8: abort empties the word
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort |=> (cnt_q == '0 && !done_o));
  // R6: an idle frame leaves the bit count alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (frame_n && !abort) |=> $stable(cnt_q));
endmodule

// File: rtl/sl_target_regs.sv
module sl_target_regs
  import sloader_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] cal_o,
  output logic              commit_o
);
  logic [WORD_W-1:0] bank_q [NUM_TGT];

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst) bank_q[t] <= '0;
      else if (wr_en && (wr_sel == 1'(t))) bank_q[t] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) commit_o <= 1'b0;
    else commit_o <= wr_en;
  end

  assign ctrl_o = bank_q[int'(TGT_CTRL)];
  assign cal_o  = bank_q[int'(TGT_CAL)];

  // R2: commit strobe lasts one cycle
  a_r2_commit_pulse: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);
  // R3: registers only change along with a commit
  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_o |-> $stable(ctrl_o));
  a_r3_cal_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_o |-> $stable(cal_o));
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int WORD_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sel_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] cal_o,
  output logic              commit_o,
  output logic              sel_err_o
);
  logic       s_frame_n;
  logic [2:0] s_lines;
  logic              done;
  logic              done_sel;
  logic [WORD_W-1:0] word;

  sl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_frame (
    .clk(clk), .rst(rst), .d(frame_n_i), .q(s_frame_n));

  sl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync_lines (
    .clk(clk), .rst(rst), .d({sclk_i, sel_i, sdata_i}), .q(s_lines));

  sl_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst(rst), .abort(abort_i),
    .sclk(s_lines[2]), .frame_n(s_frame_n), .sel(s_lines[1]), .sdata(s_lines[0]),
    .done_o(done), .done_sel_o(done_sel), .word_o(word), .err_o(sel_err_o));

  sl_target_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(done), .wr_sel(done_sel), .wr_data(word),
    .ctrl_o(ctrl_o), .cal_o(cal_o), .commit_o(commit_o));

  // R7: error and commit never coincide at the ports
  a_r7_err_no_commit: assert property (@(posedge clk) disable iff (rst)
    sel_err_o |=> !commit_o);
endmodule

// File: tb/serial_word_loader_tb.sv
module serial_word_loader_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic abort_i = 1'b0, sclk_i = 1'b0, frame_n_i = 1'b1, sel_i = 1'b0, sdata_i = 1'b0;
  logic [23:0] ctrl_o, cal_o;
  logic commit_o, sel_err_o;

  int checks = 0, failures = 0;
  int commits = 0, errs = 0, wide = 0;
  logic prev_commit = 1'b0;
  logic [23:0] exp_ctrl = '0, exp_cal = '0;

  always #10 clk = ~clk;

  serial_word_loader u_dut (
    .clk(clk), .rst(rst), .abort_i(abort_i), .sclk_i(sclk_i), .frame_n_i(frame_n_i),
    .sel_i(sel_i), .sdata_i(sdata_i), .ctrl_o(ctrl_o), .cal_o(cal_o),
    .commit_o(commit_o), .sel_err_o(sel_err_o));

  always @(negedge clk) begin
    if (rst) prev_commit <= 1'b0;
    else begin
      if (commit_o) commits++;
      if (sel_err_o) errs++;
      if (commit_o && prev_commit) wide++;
      prev_commit <= commit_o;
    end
  end

  // {sel, split, scramble, word}
  localparam logic [30:0] VEC [6] = '{
    {1'b0, 5'd0,  1'b0, 24'hA5C31E},
    {1'b1, 5'd0,  1'b0, 24'h0F00F1},
    {1'b0, 5'd7,  1'b0, 24'h800001},
    {1'b1, 5'd12, 1'b1, 24'h7FFFFE},
    {1'b0, 5'd23, 1'b1, 24'hFFFFFF},
    {1'b1, 5'd1,  1'b0, 24'h000000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [23:0] w, input int first, input int last, input bit scr);
    for (int i = first; i <= last; i++) begin
      sdata_i = w[23-i];
      tick(2);
      sclk_i = 1'b1;
      if (scr) begin tick(3); sdata_i = ~sdata_i; tick(1); end
      else tick(4);
      sclk_i = 1'b0;
      tick(2);
    end
  endtask

  task automatic write_word(input logic [23:0] w, input bit s, input int split, input bit scr);
    sel_i = s; frame_n_i = 1'b0; tick(2);
    if (split == 0) send_bits(w, 0, 23, scr);
    else begin
      send_bits(w, 0, split-1, scr);
      tick(2); frame_n_i = 1'b1; tick(12);
      frame_n_i = 1'b0; tick(2);
      send_bits(w, split, 23, scr);
    end
    tick(2); frame_n_i = 1'b1; tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0, e0;
    tick(5); rst = 1'b0; tick(4);
    // R1 reset state
    chk(ctrl_o == 0, "R1 ctrl after reset", ctrl_o, 0);
    chk(cal_o == 0, "R1 cal after reset", cal_o, 0);
    chk(commits == 0, "R1 no commit after reset", commits, 0);

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < 6; v++) begin
      logic s; int sp; logic scr; logic [23:0] w;
      s = VEC[v][30]; sp = int'(VEC[v][29:25]); scr = VEC[v][24]; w = VEC[v][23:0];
      c0 = commits;
      write_word(w, s, sp, scr);
      if (s) exp_cal = w; else exp_ctrl = w;
      chk(commits == c0 + 1, "R2 one commit per word", commits - c0, 1);
      chk(ctrl_o == exp_ctrl, sp != 0 ? "R5 split word ctrl" : (scr ? "R4 scrambled ctrl" : "R3 ctrl target"), ctrl_o, exp_ctrl);
      chk(cal_o == exp_cal, sp != 0 ? "R5 split word cal" : (scr ? "R4 scrambled cal" : "R3 cal target"), cal_o, exp_cal);
    end
    chk(errs == 0, "R7 no spurious error", errs, 0);

    // R5 partial word held across a long gap
    c0 = commits;
    sel_i = 1'b0; frame_n_i = 1'b0; tick(2);
    send_bits(24'h123456, 0, 11, 1'b0);
    frame_n_i = 1'b1; tick(60);
    chk(commits == c0, "R5 partial word not committed", commits - c0, 0);
    frame_n_i = 1'b0; tick(2);
    send_bits(24'h123456, 12, 23, 1'b0);
    tick(2); frame_n_i = 1'b1; tick(8);
    exp_ctrl = 24'h123456;
    chk(ctrl_o == exp_ctrl, "R5 resumed word", ctrl_o, exp_ctrl);

    // R6 serial clock with frame idle
    c0 = commits;
    sdata_i = 1'b1;
    for (int k = 0; k < 6; k++) begin sclk_i = 1'b1; tick(4); sclk_i = 1'b0; tick(4); end
    chk(commits == c0, "R6 idle clocks no commit", commits - c0, 0);
    write_word(24'h00ABCD, 1'b0, 0, 1'b0);
    exp_ctrl = 24'h00ABCD;
    chk(ctrl_o == exp_ctrl, "R6 idle clocks took no bits", ctrl_o, exp_ctrl);

    // R7 select change inside an active frame
    c0 = commits; e0 = errs;
    sel_i = 1'b1; frame_n_i = 1'b0; tick(2);
    send_bits(24'h3C3C3C, 0, 9, 1'b0);
    sel_i = 1'b0; tick(6);
    chk(errs == e0 + 1, "R7 error pulse on select change", errs - e0, 1);
    send_bits(24'h3C3C3C, 10, 23, 1'b0);
    tick(2); frame_n_i = 1'b1; tick(8);
    chk(commits == c0, "R7 discarded word no commit", commits - c0, 0);
    chk(cal_o == exp_cal, "R7 cal unchanged", cal_o, exp_cal);
    chk(ctrl_o == exp_ctrl, "R7 ctrl unchanged", ctrl_o, exp_ctrl);
    chk(errs == e0 + 1, "R7 single error pulse", errs - e0, 1);
    write_word(24'h5A5A5A, 1'b1, 0, 1'b0);
    exp_cal = 24'h5A5A5A;
    chk(cal_o == exp_cal, "R7 fresh word after drop", cal_o, exp_cal);

    // R7 select change across a frame gap
    c0 = commits; e0 = errs;
    sel_i = 1'b0; frame_n_i = 1'b0; tick(2);
    send_bits(24'hFFFFFF, 0, 4, 1'b0);
    frame_n_i = 1'b1; tick(4); sel_i = 1'b1; tick(4);
    frame_n_i = 1'b0; tick(8); frame_n_i = 1'b1; tick(8);
    chk(errs == e0 + 1, "R7 gap select change flagged", errs - e0, 1);
    chk(commits == c0, "R7 gap change no commit", commits - c0, 0);

    // R8 abort drops partial word
    c0 = commits;
    sel_i = 1'b0; frame_n_i = 1'b0; tick(2);
    send_bits(24'hFFFFFF, 0, 8, 1'b0);
    abort_i = 1'b1; tick(1); abort_i = 1'b0; tick(1);
    send_bits(24'h0000C3, 0, 23, 1'b0);
    tick(2); frame_n_i = 1'b1; tick(8);
    exp_ctrl = 24'h0000C3;
    chk(commits == c0 + 1, "R8 one commit after abort", commits - c0, 1);
    chk(ctrl_o == exp_ctrl, "R8 word after abort", ctrl_o, exp_ctrl);

    chk(wide == 0, "R2 commit strobe one cycle", wide, 0);

    // R1 reset clears loaded registers
    rst = 1'b1; tick(3); rst = 1'b0; tick(2);
    chk(ctrl_o == 0, "R1 ctrl cleared", ctrl_o, 0);
    chk(cal_o == 0, "R1 cal cleared", cal_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule